// File: doc/BRIEF.md
# Sub-cycle dithered PWM generator

This block produces a fixed-frequency pulse-width-modulated output from an 8-bit duty value. A full period lasts 256 ticks of the PWM clock. To push the output ripple to a higher frequency, the period is cut into either two or four equal modulation sub-cycles. The upper bits of the duty value (the coarse part) set a base high time that every sub-cycle repeats. The lower bits (the fine part) add a single extra high tick to the first few sub-cycles. Averaged over the full period, the high time still equals the duty value.

The PWM clock arrives as a clock-enable pulse on the fast system clock, so any source divider stays outside the block. Software writes a duty value, a mode and an on/off bit. The split into sub-cycles needs no further action. The duty value and the mode are captured only at the boundary of a full period, so a write never produces a torn period.

Top module: `subcycle_pwm`

## Requirements
- R1: The period counter advances only on cycles where `pwm_tick_i` is high, and a full period spans 256 ticks.
- R2: With `split_i` = 1 (quad mode), the period holds four sub-cycles of 64 ticks. The coarse value is duty bits [7:2] and the fine value is duty bits [1:0].
- R3: With `split_i` = 0 (dual mode), the period holds two sub-cycles of 128 ticks. The coarse value is duty bits [7:1] and the fine value is duty bit [0].
- R4: In sub-cycle i (numbered from 0), the output is high for coarse+1 ticks when i is less than the fine value, and for coarse ticks otherwise. The high part comes first and the output is low for the rest of the sub-cycle.
- R5: `duty_i` and `split_i` are sampled only on the tick that begins a full period. A change at any other time leaves the running period unchanged.
- R6: While `run_i` is low, the output is low at once and the counter returns to zero on the next tick. The first tick with `run_i` high begins sub-cycle 0 with freshly sampled settings.
- R7: A duty value of 0 gives a constant low output.
- R8: The last tick of every full period is low in both modes, so the output is never high for a whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_tick_i | input | 1 | Enable pulse from the selected PWM clock source |
| duty_i | input | 8 | Requested duty value |
| split_i | input | 1 | Sub-cycle mode: 0 = two sub-cycles, 1 = four sub-cycles |
| run_i | input | 1 | PWM on/off |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions check four things on every cycle: the counter is frozen between ticks and steps by one within a period, captured settings change only at a period boundary, and the output is low when disabled, for zero duty and on the last tick of a period. A period that starts with a nonzero duty must also open high. The distribution of extra high ticks across sub-cycles can only be shown by the bench. It sweeps every duty value in both modes and counts the high ticks of each sub-cycle. The bench's scenarios also show that a mid-period write is deferred, that sparse ticks stretch the waveform, and that a restart aligns to sub-cycle 0.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  typedef enum logic {
    SPLIT_DUAL = 1'b0,
    SPLIT_QUAD = 1'b1
  } split_mode_e;
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_dither_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  split_mode_e       mode_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic [DUTY_W-1:0] duty_o,
  output split_mode_e       mode_o,
  output logic              active_o
);
  localparam logic [DUTY_W-1:0] CNT_LAST = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt_q, cnt_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  split_mode_e       mode_q, mode_d;
  logic              active_q, active_d;

  always_comb begin
    cnt_d    = cnt_q;
    duty_d   = duty_q;
    mode_d   = mode_q;
    active_d = active_q;
    if (tick_i) begin
      if (!run_i) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else if (!active_q || cnt_q == CNT_LAST) begin
        // period boundary: capture shadow copies
        active_d = 1'b1;
        cnt_d    = '0;
        duty_d   = duty_i;
        mode_d   = mode_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      duty_q   <= '0;
      mode_q   <= SPLIT_DUAL;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      duty_q   <= duty_d;
      mode_q   <= mode_d;
      active_q <= active_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign duty_o   = duty_q;
  assign mode_o   = mode_q;
  assign active_o = active_q;
endmodule

// File: rtl/pwm_subcycle_cmp.sv
module pwm_subcycle_cmp
  import pwm_dither_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  split_mode_e       mode_i,
  output logic              high_o
);
  // index 0: one fine bit (dual), index 1: two fine bits (quad)
  logic [1:0] hit;

  for (genvar g = 1; g <= 2; g++) begin : g_fine
    localparam int POS_W = DUTY_W - g;
    logic [POS_W-1:0] pos;
    logic [g-1:0]     sub;
    logic [POS_W-1:0] coarse;
    logic [g-1:0]     fine;
    logic [POS_W:0]   thr;

    always_comb begin
      pos    = cnt_i[POS_W-1:0];
      sub    = cnt_i[DUTY_W-1:POS_W];
      coarse = duty_i[DUTY_W-1:g];
      fine   = duty_i[g-1:0];
      thr    = {1'b0, coarse} + {{POS_W{1'b0}}, (sub < fine)};
    end

    assign hit[g-1] = ({1'b0, pos} < thr);
  end

  assign high_o = (mode_i == SPLIT_QUAD) ? hit[1] : hit[0];
endmodule

// File: rtl/subcycle_pwm.sv
module subcycle_pwm
  import pwm_dither_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              split_i,
  input  logic              run_i,
  output logic              pwm_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [DUTY_W-1:0] cnt_w;
  logic [DUTY_W-1:0] duty_w;
  split_mode_e       mode_w;
  logic              active_w;
  logic              high_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pwm_period_ctr #(.DUTY_W(DUTY_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick_i   (pwm_tick_i),
    .run_i    (run_i),
    .duty_i   (duty_i),
    .mode_i   (split_mode_e'(split_i)),
    .cnt_o    (cnt_w),
    .duty_o   (duty_w),
    .mode_o   (mode_w),
    .active_o (active_w)
  );

  pwm_subcycle_cmp #(.DUTY_W(DUTY_W)) u_cmp (
    .cnt_i  (cnt_w),
    .duty_i (duty_w),
    .mode_i (mode_w),
    .high_o (high_w)
  );

  assign pwm_o = active_w & run_i & high_w;
endmodule

// File: rtl/subcycle_pwm_chk.sv
module subcycle_pwm_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_tick_i,
  input logic              run_i,
  input logic              pwm_o,
  input logic [DUTY_W-1:0] cnt_w,
  input logic [DUTY_W-1:0] duty_w,
  input logic              active_w
);
  localparam logic [DUTY_W-1:0] CNT_LAST = {DUTY_W{1'b1}};

  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_tick_i |=> $stable(cnt_w));

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_tick_i && run_i && active_w && cnt_w != CNT_LAST) |=> (cnt_w == $past(cnt_w) + 1'b1));

  p_shadow_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_w) |-> (cnt_w == '0));

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !pwm_o);

  p_zero_duty_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_w == '0) |-> !pwm_o);

  p_last_tick_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w == CNT_LAST) |-> !pwm_o);

  p_opens_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && run_i && cnt_w == '0 && duty_w != '0) |-> pwm_o);
endmodule

bind subcycle_pwm subcycle_pwm_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_tick_i (pwm_tick_i),
  .run_i      (run_i),
  .pwm_o      (pwm_o),
  .cnt_w      (cnt_w),
  .duty_w     (duty_w),
  .active_w   (active_w)
);

// File: tb/tb_subcycle_pwm.sv
module tb_subcycle_pwm;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       pwm_tick_i;
  logic [7:0] duty_i;
  logic       split_i;
  logic       run_i;
  logic       pwm_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_run;
  int m_ph;
  int m_duty;
  bit m_quad;

  subcycle_pwm dut (
    .clk(clk), .rst_n(rst_n), .pwm_tick_i(pwm_tick_i),
    .duty_i(duty_i), .split_i(split_i), .run_i(run_i), .pwm_o(pwm_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_level(int ph, int duty, bit quad);
    int n, len, i, off, dc, ac;
    n   = quad ? 4 : 2;
    len = 256 / n;
    i   = ph / len;
    off = ph % len;
    dc  = duty / n;
    ac  = duty % n;
    return off < dc + ((i < ac) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_ph <= 0; m_duty <= 0; m_quad <= 0;
    end else if (pwm_tick_i) begin
      if (!run_i) begin
        m_run <= 0; m_ph <= 0;
      end else if (!m_run || m_ph == 255) begin
        m_run <= 1; m_ph <= 0; m_duty <= duty_i; m_quad <= split_i;
      end else begin
        m_ph <= m_ph + 1;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      bit e;
      e = m_run && run_i && ref_level(m_ph, m_duty, m_quad);
      chk(pwm_o === e, cur_req, pwm_o, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  // sweep one full period from a fresh start, count high ticks per sub-cycle
  task automatic sweep_one(int duty, bit quad);
    int hi[4];
    int n, len, dc, ac, total;
    n = quad ? 4 : 2; len = 256 / n; dc = duty / n; ac = duty % n; total = 0;
    for (int s = 0; s < 4; s++) hi[s] = 0;
    @(negedge clk); run_i = 0;
    @(negedge clk); duty_i = duty[7:0]; split_i = quad; run_i = 1;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); #1;
      if (pwm_o) begin hi[k / len]++; total++; end
      if (k == 255) chk(pwm_o == 0, "R8", pwm_o, 0);
    end
    for (int s = 0; s < n; s++)
      chk(hi[s] == dc + ((s < ac) ? 1 : 0), quad ? "R4 R2" : "R4 R3",
          hi[s], dc + ((s < ac) ? 1 : 0));
    if (duty == 0) chk(total == 0, "R7", total, 0);
  endtask

  initial begin
    rst_n = 0; pwm_tick_i = 1; duty_i = 0; split_i = 0; run_i = 0;
    repeat (3) @(negedge clk);
    #1 chk(pwm_o == 0, "R6 reset", pwm_o, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // full sweep, both modes
    cur_req = "R4";
    for (int q = 0; q < 2; q++)
      for (int d = 0; d < 256; d++)
        sweep_one(d, q[0]);

    // sparse ticks stretch the waveform
    cur_req = "R1";
    @(negedge clk); run_i = 0;
    @(negedge clk); duty_i = 8'd77; split_i = 1; run_i = 1;
    for (int k = 0; k < 700; k++) begin
      @(negedge clk); pwm_tick_i = (k % 3 == 0);
    end
    @(negedge clk); pwm_tick_i = 1;

    // mid-period writes are deferred
    cur_req = "R5";
    @(negedge clk); run_i = 0;
    @(negedge clk); duty_i = 8'd200; split_i = 0; run_i = 1;
    repeat (90) @(negedge clk);
    duty_i = 8'd13; split_i = 1;
    repeat (20) @(negedge clk);
    duty_i = 8'd131; split_i = 0;
    repeat (600) @(negedge clk);

    // disable in the middle of a high stretch
    cur_req = "R6";
    duty_i = 8'd250; split_i = 1;
    repeat (300) @(negedge clk);
    run_i = 0;
    #1 chk(pwm_o == 0, "R6 disable", pwm_o, 0);
    repeat (5) @(negedge clk);
    duty_i = 8'd5; split_i = 1; run_i = 1;
    @(negedge clk); #1 chk(pwm_o == 1, "R6 restart", pwm_o, 1);
    repeat (400) @(negedge clk);

    cmp_on = 0;
    @(negedge clk);
    finish_run();
  end
endmodule